// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives up to four audio channels carried as stereo pairs on two serial data lines. The bit clock and frame clock are driven by an external source, so the block works as a slave. All three kinds of input are brought into the system clock domain through synchronizer chains. The selected edge of the bit clock is detected there, and each data line is sampled on that edge.

A three-bit format code chooses among seven frame layouts. The layouts differ in slot length (32 or 24 bit clocks per channel half), word length (24 or 16 bits), justification and an optional one-bit delay after the frame-clock edge. Two polarity inputs choose the active bit-clock edge and the frame-clock level that marks the left channel.

At every frame-clock transition the word captured during the half-frame that just ended is committed to the left or right output register of its lane. When a right word is committed, a one-cycle valid pulse marks a complete stereo pair. A reserved code, or a code that only works in slave operation while the surrounding system declares master operation, sets a sticky error flag. While that flag is set, no valid pulses are produced.

Top module: `audrx_top`

## Requirements
- R1: The format code selects the bit indices captured within each half-frame, where index 0 is the first active edge after a frame-clock change. The code values and their index ranges are: 0 captures 0..23 of a 32-bit slot; 1 captures 1..24 of a 32-bit slot (one-bit delay, the default I2S layout); 2 captures 16..31 as a 16-bit word; 3 captures 8..31; 4 captures 0..23 of a 24-bit slot; 6 captures 8..23 as a 16-bit word; 7 captures 0..23 of a 24-bit slot.
- R2: With bit-clock polarity 1, data is sampled on rising bit-clock edges; with polarity 0, on falling edges.
- R3: A half-frame during which the frame clock equals the frame-clock polarity input is a left channel; the other level is a right channel.
- R4: The bit index restarts at 0 on the active edge where the frame-clock level differs from the level at the previous active edge. On every other active edge it advances by one, and it saturates at 63.
- R5: Words arrive MSB first. A 16-bit word is placed in bits 23:8 of the 24-bit output, and bits 7:0 are zero.
- R6: On a frame-clock change, the word of the half-frame that just ended is written to that lane's left or right output. Output words change at no other time. The first change after reset commits nothing.
- R7: Each commit of a right word produces exactly one system-clock-cycle pulse on the valid bit of every lane.
- R8: Data bits at indices outside the selected range have no effect on the output words.
- R9: Code 5, or code 4, 6 or 7 while the master input is high, sets the error flag within one clock. The flag then stays high until reset.
- R10: While the error flag is high, no valid pulse is produced.
- R11: After reset, all output words, the valid bits and the error flag are zero.
- R12: Both data lines are captured concurrently on the shared clocks, each into its own lane outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Frame format code |
| cfg_bclk_pol | input | 1 | 1: rising bit-clock edge active; 0: falling |
| cfg_lrck_pol | input | 1 | Frame-clock level that marks the left channel |
| cfg_master | input | 1 | High when the system treats the interface as master |
| bclk_in | input | 1 | Serial bit clock |
| lrck_in | input | 1 | Frame (left/right) clock |
| sd_in | input | NUM_LANES | Serial data, one bit per lane |
| left_out | output | NUM_LANES x 24 | Committed left word per lane |
| right_out | output | NUM_LANES x 24 | Committed right word per lane |
| valid_out | output | NUM_LANES | One-cycle pulse per lane when a pair completes |
| mode_err | output | 1 | Sticky illegal-format flag |

## Verification
Outside the capture window the bench drives ones. A design with an off-by-one window or a missing delay therefore produces shifted or polluted words instead of clean values. Right-justified and 16-bit layouts are run back to back. A design that counts from the wrong end of the slot, or that fills the wrong end of a short word, miscompares every sample. A run with inverted polarities catches a design that samples on the idle edge or swaps channels. Error runs expect no pulses at all, so a design whose flag does not stick, or that forgets to gate the strobe, is caught when the monitor finds an unexpected pair.

// File: rtl/audrx_pkg.sv
package audrx_pkg;
  localparam int IDX_W  = 6;
  localparam int WORD_W = 24;

  typedef struct packed {
    logic [IDX_W-1:0] first;
    logic [IDX_W-1:0] last;
    logic             short_word;
    logic             reserved;
    logic             slave_only;
  } fmt_t;

  function automatic fmt_t decode_fmt(input logic [2:0] code);
    fmt_t f;
    f = '{first: 6'd1, last: 6'd24, short_word: 1'b0, reserved: 1'b0, slave_only: 1'b0};
    case (code)
      3'd0: begin f.first = 6'd0;  f.last = 6'd23; end
      3'd1: begin f.first = 6'd1;  f.last = 6'd24; end
      3'd2: begin f.first = 6'd16; f.last = 6'd31; f.short_word = 1'b1; end
      3'd3: begin f.first = 6'd8;  f.last = 6'd31; end
      3'd4: begin f.first = 6'd0;  f.last = 6'd23; f.slave_only = 1'b1; end
      3'd5: begin f.reserved = 1'b1; end
      3'd6: begin f.first = 6'd8;  f.last = 6'd23; f.short_word = 1'b1; f.slave_only = 1'b1; end
      default: begin f.first = 6'd0; f.last = 6'd23; f.slave_only = 1'b1; end
    endcase
    return f;
  endfunction

  function automatic logic [WORD_W-1:0] place_word(input logic [WORD_W-1:0] sh,
                                                   input logic short_word);
    return short_word ? {sh[15:0], 8'h00} : sh;
  endfunction
endpackage

// File: rtl/audrx_sync.sv
module audrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/audrx_timer.sv
module audrx_timer
  import audrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev,
  input  logic             lr_now,
  input  logic             lrck_pol,
  output logic [IDX_W-1:0] cur_idx,
  output logic             restart,
  output logic             commit,
  output logic             ended_left
);
  logic             started, armed, lr_last;
  logic [IDX_W-1:0] idx_q;
  logic             lr_change;

  assign lr_change  = started && (lr_now != lr_last);
  assign restart    = ev && lr_change;
  assign commit     = restart && armed;
  assign ended_left = (lr_last == lrck_pol);

  always_comb begin
    if (!started || lr_change)  cur_idx = '0;
    else if (&idx_q)            cur_idx = idx_q;
    else                        cur_idx = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      armed   <= 1'b0;
      lr_last <= 1'b0;
      idx_q   <= '0;
    end else if (ev) begin
      started <= 1'b1;
      lr_last <= lr_now;
      idx_q   <= cur_idx;
      if (restart) armed <= 1'b1;
    end
  end

  p_idx_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (idx_q == '0));

  p_idx_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && started && !lr_change && !(&idx_q)) |=> (idx_q == $past(idx_q) + 6'd1));
endmodule

// File: rtl/audrx_lane.sv
module audrx_lane
  import audrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev,
  input  logic              restart,
  input  logic              commit,
  input  logic              ended_left,
  input  logic              allow,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [IDX_W-1:0]  win_first,
  input  logic [IDX_W-1:0]  win_last,
  input  logic              win_short,
  input  logic              sd,
  output logic [WORD_W-1:0] left_q,
  output logic [WORD_W-1:0] right_q,
  output logic              pair_done
);
  logic [WORD_W-1:0] sh;
  logic              in_win;
  logic [WORD_W-1:0] word;

  assign in_win = (cur_idx >= win_first) && (cur_idx <= win_last);
  assign word   = place_word(sh, win_short);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      left_q    <= '0;
      right_q   <= '0;
      pair_done <= 1'b0;
    end else begin
      pair_done <= commit && !ended_left && allow;
      if (ev) begin
        if (restart) begin
          if (commit) begin
            if (ended_left) left_q  <= word;
            else            right_q <= word;
          end
          sh <= in_win ? {{(WORD_W-1){1'b0}}, sd} : '0;
        end else if (in_win) begin
          sh <= {sh[WORD_W-2:0], sd};
        end
      end
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(left_q) && $stable(right_q)));
endmodule

// File: rtl/audrx_top.sv
module audrx_top
  import audrx_pkg::*;
#(
  parameter int NUM_LANES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [2:0]                        cfg_mode,
  input  logic                              cfg_bclk_pol,
  input  logic                              cfg_lrck_pol,
  input  logic                              cfg_master,
  input  logic                              bclk_in,
  input  logic                              lrck_in,
  input  logic [NUM_LANES-1:0]              sd_in,
  output logic [NUM_LANES-1:0][WORD_W-1:0]  left_out,
  output logic [NUM_LANES-1:0][WORD_W-1:0]  right_out,
  output logic [NUM_LANES-1:0]              valid_out,
  output logic                              mode_err
);
  fmt_t             fmt;
  logic             fmt_bad;
  logic             bclk_s, bclk_d, lrck_s;
  logic [NUM_LANES-1:0] sd_s;
  logic             act_edge;
  logic [IDX_W-1:0] cur_idx;
  logic             restart, commit, ended_left;
  logic             err_q;

  assign fmt     = decode_fmt(cfg_mode);
  assign fmt_bad = fmt.reserved || (cfg_master && fmt.slave_only);

  audrx_sync #(.STAGES(SYNC_STAGES)) u_sync_bclk (.clk(clk), .rst_n(rst_n), .d_in(bclk_in), .d_out(bclk_s));
  audrx_sync #(.STAGES(SYNC_STAGES)) u_sync_lrck (.clk(clk), .rst_n(rst_n), .d_in(lrck_in), .d_out(lrck_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      bclk_d <= bclk_s;
      err_q  <= err_q | fmt_bad;
    end
  end

  assign act_edge = cfg_bclk_pol ? (bclk_s & ~bclk_d) : (~bclk_s & bclk_d);
  assign mode_err = err_q;

  audrx_timer u_timer (
    .clk(clk), .rst_n(rst_n), .ev(act_edge), .lr_now(lrck_s), .lrck_pol(cfg_lrck_pol),
    .cur_idx(cur_idx), .restart(restart), .commit(commit), .ended_left(ended_left)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    audrx_sync #(.STAGES(SYNC_STAGES)) u_sync_sd (
      .clk(clk), .rst_n(rst_n), .d_in(sd_in[g]), .d_out(sd_s[g])
    );
    audrx_lane u_lane (
      .clk(clk), .rst_n(rst_n), .ev(act_edge), .restart(restart), .commit(commit),
      .ended_left(ended_left), .allow(!(err_q || fmt_bad)), .cur_idx(cur_idx),
      .win_first(fmt.first), .win_last(fmt.last), .win_short(fmt.short_word),
      .sd(sd_s[g]), .left_q(left_out[g]), .right_q(right_out[g]), .pair_done(valid_out[g])
    );
  end

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  p_err_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_bad |=> err_q);

  p_no_valid_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (valid_out == '0));

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out != '0) |=> (valid_out == '0));
endmodule

// File: tb/audrx_top_bench.sv
module audrx_top_bench;
  localparam int HALF = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                   rst_n;
  logic [2:0]             cfg_mode;
  logic                   cfg_bclk_pol, cfg_lrck_pol, cfg_master;
  logic                   bclk_in, lrck_in;
  logic [1:0]             sd_in;
  logic [1:0][23:0]       left_out, right_out;
  logic [1:0]             valid_out;
  logic                   mode_err;

  audrx_top u_audrx_top (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_bclk_pol(cfg_bclk_pol),
    .cfg_lrck_pol(cfg_lrck_pol), .cfg_master(cfg_master), .bclk_in(bclk_in),
    .lrck_in(lrck_in), .sd_in(sd_in), .left_out(left_out), .right_out(right_out),
    .valid_out(valid_out), .mode_err(mode_err)
  );

  typedef struct packed { logic [23:0] l0, r0, l1, r1; } pair_t;
  pair_t q[$];
  int n_chk = 0, n_fail = 0, strobes = 0;
  bit done = 0;
  string cur_tag = "R1";

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: scoreboard consumer
  always @(negedge clk) begin
    if (rst_n && valid_out != 2'b00) begin
      pair_t e;
      strobes++;
      chk("R12", {30'd0, valid_out}, 32'd3);
      if (q.size() == 0) chk("R10", {30'd0, valid_out}, 32'd0);
      else begin
        e = q.pop_front();
        chk(cur_tag, {8'd0, left_out[0]},  {8'd0, e.l0});
        chk(cur_tag, {8'd0, right_out[0]}, {8'd0, e.r0});
        chk(cur_tag, {8'd0, left_out[1]},  {8'd0, e.l1});
        chk(cur_tag, {8'd0, right_out[1]}, {8'd0, e.r1});
      end
    end
  end

  function automatic int slot_of(input logic [2:0] m); return (m >= 3'd4) ? 24 : 32; endfunction
  function automatic int wlen_of(input logic [2:0] m); return (m == 3'd2 || m == 3'd6) ? 16 : 24; endfunction

  function automatic logic bit_at(input logic [2:0] m, input int i, input logic [23:0] w);
    int s, wl, st, k;
    s  = slot_of(m);
    wl = wlen_of(m);
    if (m == 3'd1)                          st = 1;
    else if (m == 3'd2 || m == 3'd3 || m == 3'd6) st = s - wl;
    else                                    st = 0;
    k = i - st;
    if (k < 0 || k >= wl) return 1'b1;   // R8: junk outside window
    return w[wl-1-k];
  endfunction

  function automatic logic [23:0] expect_word(input logic [2:0] m, input logic [23:0] w);
    return (wlen_of(m) == 16) ? {w[15:0], 8'h00} : w;   // R5
  endfunction

  task automatic drive_bit(input logic lr, input logic [1:0] d);
    @(negedge clk);
    bclk_in = ~cfg_bclk_pol; lrck_in = lr; sd_in = d;
    repeat (HALF) @(negedge clk);
    bclk_in = cfg_bclk_pol;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic send_half(input logic [2:0] m, input logic lr, input logic [23:0] w0, input logic [23:0] w1);
    for (int i = 0; i < slot_of(m); i++) drive_bit(lr, {bit_at(m, i, w1), bit_at(m, i, w0)});
  endtask

  task automatic run_cfg(input logic [2:0] m, input logic bp, input logic lp, input logic ms,
                         input int nfr, input string tag, input logic exp_err, input bit chk_reset);
    logic [2:0] tm;
    tm = (m == 3'd5) ? 3'd1 : m;
    cfg_mode = m; cfg_bclk_pol = bp; cfg_lrck_pol = lp; cfg_master = ms;
    bclk_in = ~bp; lrck_in = ~lp; sd_in = 2'b00;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    if (chk_reset) begin
      chk("R11", {left_out[0], 8'd0}, 32'd0);
      chk("R11", {right_out[1], 8'd0}, 32'd0);
      chk("R11", {29'd0, valid_out, mode_err}, 32'd0);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", {31'd0, mode_err}, {31'd0, exp_err});
    cur_tag = tag;
    strobes = 0;
    send_half(tm, ~lp, 24'h0, 24'h0);
    for (int f = 0; f < nfr; f++) begin
      logic [23:0] l0, r0, l1, r1;
      l0 = 24'($urandom); r0 = 24'($urandom); l1 = 24'($urandom); r1 = 24'($urandom);
      if (!exp_err) q.push_back('{expect_word(tm, l0), expect_word(tm, r0),
                                  expect_word(tm, l1), expect_word(tm, r1)});
      send_half(tm, lp, l0, l1);
      send_half(tm, ~lp, r0, r1);
    end
    send_half(tm, lp, 24'h0, 24'h0);
    repeat (20) @(negedge clk);
    chk(exp_err ? "R10" : "R7", strobes, exp_err ? 0 : nfr);
    chk("R6", q.size(), 0);
    chk("R9", {31'd0, mode_err}, {31'd0, exp_err});
    q.delete();
  endtask

  initial begin
    rst_n = 1'b0; cfg_mode = 3'd1; cfg_bclk_pol = 1'b1; cfg_lrck_pol = 1'b0; cfg_master = 1'b0;
    bclk_in = 1'b0; lrck_in = 1'b1; sd_in = 2'b00;
    run_cfg(3'd1, 1'b1, 1'b0, 1'b0, 3, "R1 mode1", 1'b0, 1'b1);
    run_cfg(3'd0, 1'b1, 1'b0, 1'b0, 3, "R1 mode0", 1'b0, 1'b0);
    run_cfg(3'd2, 1'b1, 1'b0, 1'b0, 3, "R5 mode2", 1'b0, 1'b0);
    run_cfg(3'd3, 1'b1, 1'b0, 1'b0, 3, "R8 mode3", 1'b0, 1'b0);
    run_cfg(3'd4, 1'b1, 1'b0, 1'b0, 3, "R1 mode4", 1'b0, 1'b0);
    run_cfg(3'd6, 1'b1, 1'b0, 1'b0, 3, "R5 mode6", 1'b0, 1'b0);
    run_cfg(3'd7, 1'b1, 1'b0, 1'b0, 3, "R1 mode7", 1'b0, 1'b0);
    run_cfg(3'd1, 1'b0, 1'b1, 1'b0, 3, "R2 R3 inverted", 1'b0, 1'b0);
    run_cfg(3'd3, 1'b1, 1'b0, 1'b1, 2, "R4 master legal", 1'b0, 1'b0);
    run_cfg(3'd5, 1'b1, 1'b0, 1'b0, 2, "R9 reserved", 1'b1, 1'b0);
    run_cfg(3'd6, 1'b1, 1'b0, 1'b1, 2, "R9 master slave-only", 1'b1, 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule